// File: doc/BRIEF.md
# VLIW Execute Packet Dispatcher

This block sits between instruction fetch and the functional units of a wide-issue core. It takes in one fetch packet at a time. A fetch packet is a group of eight instruction words, and it arrives over a valid/ready handshake. The block reads a chaining flag in each word and uses it to cut the packet into execute packets. It then issues one execute packet per cycle onto a row of eight functional-unit slots. Each slot carries a valid bit and an instruction word.

Serial code and parallel code fetch at different rates. A fully parallel fetch packet leaves in one cycle. A fully serial one needs eight cycles. The block refuses new fetch packets until the one it holds is used up, and it accepts the next packet in the same cycle that its last execute packet issues. A stall input from downstream freezes the slot outputs and the dispatch position.

Top module: `ep_dispatch`

## Requirements
- R1: A fetch packet is captured only on a clock edge where `fp_valid_i` and `fp_ready_o` are both high. A packet offered while `fp_ready_o` is low is not captured and produces no slot output.
- R2: Bit 0 of each instruction word is the chaining flag. If it is 1, the following word of the same fetch packet joins the current execute packet. If it is 0, the execute packet ends with that word.
- R3: Bit 0 of word 7, the last word of a fetch packet, is ignored. An execute packet never continues into the next fetch packet.
- R4: Execute packets are issued one per cycle in program order, including across fetch packets. The first execute packet of a captured fetch packet appears on the slots one cycle after the capture edge. Example: a 2/3/3 split followed by a fully parallel packet issues as 2, 3, 3, 8.
- R5: An execute packet of n words sits on slots 0 to n-1, in program order. The valid bits of the other slots are 0, and their words read 0.
- R6: `fp_ready_o` is high when no fetch packet is held, or when the last execute packet of the held packet issues in the current cycle. Otherwise it is low. With `fp_valid_i` held high, consecutive fetch packets issue with no empty cycle between them.
- R7: While `stall_i` is high, the slot outputs and the dispatch position keep their values and `fp_ready_o` is low. After the stall, dispatch resumes at the next execute packet and no packet is lost.
- R8: A synchronous active-high reset empties the held fetch packet and clears every slot valid bit. `fp_ready_o` is high as soon as reset ends.
- R9: If no fetch packet is held and `stall_i` is low, all slot valid bits are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid_i | input | 1 | A fetch packet is offered |
| fp_ready_o | output | 1 | The block can capture a fetch packet on this edge |
| fp_word_i | input | LANES*IW | Eight instruction words, word i at bits [i*IW +: IW] |
| stall_i | input | 1 | Downstream stall; freezes dispatch |
| slot_valid_o | output | LANES | Per-slot valid |
| slot_word_o | output | LANES*IW | Per-slot instruction word, slot s at bits [s*IW +: IW] |

## Verification
The dispatch position is internal state. If it goes wrong, the result shows up at the slots on the very next issue cycle: words are skipped or repeated, the slot mask has the wrong size, or packets arrive in the wrong order. The bench tags every word with its fetch packet and its position and compares each execute packet with a model built from the flags, so any such error causes a mismatch within one cycle. If the held-packet state is wrong, `fp_ready_o` rises early or late. An early rise overwrites words and fails the word compare. A late rise adds an empty cycle and fails the issue-span count.

// File: rtl/ep_pkg.sv
package ep_pkg;
    localparam int EP_LANES = 8;
    localparam int EP_IW    = 32;
    localparam int EP_CHAIN_BIT = 0;
endpackage

// File: rtl/ep_boundary.sv
module ep_boundary #(
    parameter int LANES = 8,
    parameter int PW    = $clog2(LANES),
    parameter int IW    = 32,
    parameter int CHAIN = 0
) (
    input  logic [LANES-1:0][IW-1:0] words_i,
    input  logic [PW-1:0]            start_i,
    output logic [PW-1:0]            stop_o,
    output logic                     final_o
);
    logic found;

    always_comb begin
        stop_o = PW'(LANES - 1);
        found  = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            if (!found && j >= int'(start_i) &&
                (!words_i[j][CHAIN] || j == LANES - 1)) begin
                stop_o = PW'(j);
                found  = 1'b1;
            end
        end
        final_o = (stop_o == PW'(LANES - 1));
    end
endmodule

// File: rtl/ep_slot_pack.sv
module ep_slot_pack #(
    parameter int LANES = 8,
    parameter int PW    = $clog2(LANES),
    parameter int IW    = 32
) (
    input  logic [LANES-1:0][IW-1:0] words_i,
    input  logic [PW-1:0]            start_i,
    input  logic [PW-1:0]            stop_i,
    output logic [LANES-1:0]         valid_o,
    output logic [LANES-1:0][IW-1:0] slots_o
);
    for (genvar s = 0; s < LANES; s++) begin : g_slot
        logic [PW:0] src;
        assign src        = {1'b0, start_i} + (PW+1)'(s);
        assign valid_o[s] = (src <= {1'b0, stop_i});
        assign slots_o[s] = valid_o[s] ? words_i[src[PW-1:0]] : '0;
    end
endmodule

// File: rtl/ep_dispatch.sv
module ep_dispatch #(
    parameter int LANES = ep_pkg::EP_LANES,
    parameter int IW    = ep_pkg::EP_IW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  fp_valid_i,
    output logic                  fp_ready_o,
    input  logic [LANES*IW-1:0]   fp_word_i,
    input  logic                  stall_i,
    output logic [LANES-1:0]      slot_valid_o,
    output logic [LANES*IW-1:0]   slot_word_o
);
    localparam int PW = $clog2(LANES);

    typedef struct packed {
        logic                     held;
        logic [PW-1:0]            ptr;
        logic [LANES-1:0][IW-1:0] words;
        logic [LANES-1:0]         sv;
        logic [LANES-1:0][IW-1:0] sw;
    } state_t;

    state_t st_q, st_d;

    logic [PW-1:0]            stop_w;
    logic                     final_w;
    logic [LANES-1:0]         pk_valid;
    logic [LANES-1:0][IW-1:0] pk_slots;
    logic                     ready_w;
    logic                     held_w;

    ep_boundary #(.LANES(LANES), .PW(PW), .IW(IW), .CHAIN(ep_pkg::EP_CHAIN_BIT)) bnd_i (
        .words_i (st_q.words),
        .start_i (st_q.ptr),
        .stop_o  (stop_w),
        .final_o (final_w)
    );

    ep_slot_pack #(.LANES(LANES), .PW(PW), .IW(IW)) pack_i (
        .words_i (st_q.words),
        .start_i (st_q.ptr),
        .stop_i  (stop_w),
        .valid_o (pk_valid),
        .slots_o (pk_slots)
    );

    assign ready_w = (!st_q.held || final_w) && !stall_i;

    always_comb begin
        st_d = st_q;
        if (!stall_i) begin
            if (st_q.held) begin
                st_d.sv  = pk_valid;
                st_d.sw  = pk_slots;
                st_d.ptr = PW'(stop_w + PW'(1));
                if (final_w) begin
                    st_d.held = 1'b0;
                    st_d.ptr  = '0;
                end
            end else begin
                st_d.sv = '0;
                st_d.sw = '0;
            end
        end
        if (fp_valid_i && ready_w) begin
            st_d.words = fp_word_i;
            st_d.ptr   = '0;
            st_d.held  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fp_ready_o   = ready_w;
    assign slot_valid_o = st_q.sv;
    assign slot_word_o  = st_q.sw;
    assign held_w       = st_q.held;
endmodule

// File: rtl/ep_dispatch_chk.sv
module ep_dispatch_chk #(
    parameter int LANES = 8,
    parameter int IW    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                stall_i,
    input logic                fp_ready_o,
    input logic [LANES-1:0]    slot_valid_o,
    input logic [LANES*IW-1:0] slot_word_o,
    input logic                held
);
    p_stall_blocks_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        stall_i |-> !fp_ready_o);

    p_stall_holds_slots_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(stall_i)) |-> ($stable(slot_valid_o) && $stable(slot_word_o)));

    p_contiguous_slots_r5: assert property (@(posedge clk) disable iff (rst)
        ((slot_valid_o & LANES'(slot_valid_o + LANES'(1))) == '0));

    p_issue_each_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(held) && !$past(stall_i)) |-> slot_valid_o[0]);

    p_idle_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (!held && !stall_i) |-> fp_ready_o);

    p_empty_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_valid_o == '0 && !held));
endmodule

bind ep_dispatch ep_dispatch_chk #(.LANES(LANES), .IW(IW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .fp_ready_o   (fp_ready_o),
    .slot_valid_o (slot_valid_o),
    .slot_word_o  (slot_word_o),
    .held         (held_w)
);

// File: tb/ep_dispatch_tb_top.sv
`timescale 1ns/1ps
module ep_dispatch_tb_top;
    localparam int L = 8;
    localparam int W = 32;
    localparam int NV = 6;
    localparam logic [7:0] FLAGS [NV] = '{8'h6D, 8'h7F, 8'h00, 8'hFF, 8'h55, 8'h01};
    localparam int NEP [NV] = '{3, 1, 8, 1, 4, 7};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fp_valid_i = 1'b0;
    logic fp_ready_o;
    logic [L*W-1:0] fp_word_i = '0;
    logic stall_i = 1'b0;
    logic [L-1:0] slot_valid_o;
    logic [L*W-1:0] slot_word_o;

    always #10 clk = ~clk;

    ep_dispatch dut_i (
        .clk(clk), .rst(rst), .fp_valid_i(fp_valid_i), .fp_ready_o(fp_ready_o),
        .fp_word_i(fp_word_i), .stall_i(stall_i),
        .slot_valid_o(slot_valid_o), .slot_word_o(slot_word_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int first_v = -1;
    int last_v = -1;
    int epc [64];
    logic upd = 1'b0;
    logic [L-1:0]   qm [$];
    logic [L*W-1:0] qw [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mkword(input int k, input int i, input logic f);
        return {16'(k), 8'(i), 7'd0, f};
    endfunction

    task automatic push_expected(input int k, input logic [7:0] fl);
        int s = 0;
        while (s < L) begin
            int e = s;
            logic [L-1:0] m = '0;
            logic [L*W-1:0] w = '0;
            while (e < L - 1 && fl[e]) e++;
            for (int j = s; j <= e; j++) begin
                m[j-s] = 1'b1;
                w[(j-s)*W +: W] = mkword(k, j, fl[j]);
            end
            qm.push_back(m);
            qw.push_back(w);
            s = e + 1;
        end
    endtask

    task automatic send(input int k, input logic [7:0] fl);
        @(negedge clk);
        fp_valid_i = 1'b1;
        for (int i = 0; i < L; i++) fp_word_i[i*W +: W] = mkword(k, i, fl[i]);
        forever begin
            #1;
            if (fp_ready_o) begin
                push_expected(k, fl);
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        upd <= !stall_i && !rst;
    end

    always @(negedge clk) begin
        if (upd && !rst && slot_valid_o != '0) begin
            if (qm.size() == 0) begin
                chk(1'b0, "R4", "unexpected execute packet", {248'd0, slot_valid_o}, '0);
            end else begin
                logic [L-1:0] m;
                logic [L*W-1:0] w;
                int id;
                m = qm.pop_front();
                w = qw.pop_front();
                chk(slot_valid_o == m, "R5", "slot mask", {248'd0, slot_valid_o}, {248'd0, m});
                chk(slot_word_o == w, "R2", "slot words", slot_word_o, w);
                id = int'(slot_word_o[31:16]);
                if (id < 64) epc[id]++;
                if (first_v < 0) first_v = cyc;
                last_v = cyc;
            end
        end
    end

    bit done = 1'b0;
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] sv;
        logic [L*W-1:0] sw;
        for (int i = 0; i < 64; i++) epc[i] = 0;
        repeat (2) @(negedge clk);
        chk(slot_valid_o == '0, "R8", "valid in reset", {248'd0, slot_valid_o}, '0);
        rst = 1'b0;
        #1;
        chk(fp_ready_o == 1'b1, "R8", "ready after reset", {255'd0, fp_ready_o}, 1);

        // Table walk: continuous stream, 2/3/3 then 8 ordering first (R4)
        for (int k = 0; k < NV; k++) send(k, FLAGS[k]);
        @(negedge clk);
        fp_valid_i = 1'b0;
        repeat (12) @(negedge clk);
        for (int k = 0; k < NV; k++)
            chk(epc[k] == NEP[k], (FLAGS[k] == 8'hFF) ? "R3" : "R2", "execute packet count",
                epc[k], NEP[k]);
        chk(last_v - first_v + 1 == 24, "R6", "issue span without bubbles",
            last_v - first_v + 1, 24);
        chk(qm.size() == 0, "R4", "pending packets", qm.size(), 0);
        chk(slot_valid_o == '0, "R9", "idle slots cleared", {248'd0, slot_valid_o}, '0);
        chk(fp_ready_o == 1'b1, "R6", "ready when empty", {255'd0, fp_ready_o}, 1);

        // R1: offer while stalled and empty -> not captured
        stall_i = 1'b1;
        fp_valid_i = 1'b1;
        for (int i = 0; i < L; i++) fp_word_i[i*W +: W] = mkword(12, i, 1'b1);
        #1;
        chk(fp_ready_o == 1'b0, "R1", "ready while stalled", {255'd0, fp_ready_o}, 0);
        repeat (3) @(negedge clk);
        chk(slot_valid_o == '0, "R1", "no capture without ready", {248'd0, slot_valid_o}, '0);
        fp_valid_i = 1'b0;
        stall_i = 1'b0;
        send(12, 8'h7F);
        @(negedge clk);
        fp_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(epc[12] == 1, "R1", "captured exactly once", epc[12], 1);

        // R7: stall in the middle of a serial fetch packet
        send(10, 8'h00);
        @(negedge clk);
        fp_valid_i = 1'b0;
        #1;
        chk(fp_ready_o == 1'b0, "R6", "ready low with packets left", {255'd0, fp_ready_o}, 0);
        repeat (2) @(negedge clk);
        stall_i = 1'b1;
        sv = slot_valid_o;
        sw = slot_word_o;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(fp_ready_o == 1'b0, "R7", "ready during stall", {255'd0, fp_ready_o}, 0);
            @(negedge clk);
            chk(slot_valid_o == sv && slot_word_o == sw, "R7", "slots frozen", slot_word_o, sw);
        end
        stall_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(epc[10] == 8, "R7", "all packets after stall", epc[10], 8);
        chk(qm.size() == 0, "R7", "none lost", qm.size(), 0);

        // R8: reset in the middle of a fetch packet
        send(11, 8'h00);
        @(negedge clk);
        fp_valid_i = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(slot_valid_o == '0, "R8", "reset clears slots", {248'd0, slot_valid_o}, '0);
        qm.delete();
        qw.delete();
        rst = 1'b0;
        #1;
        chk(fp_ready_o == 1'b1, "R8", "reset empties held packet", {255'd0, fp_ready_o}, 1);
        repeat (10) @(negedge clk);
        chk(slot_valid_o == '0, "R8", "no dispatch after reset", {248'd0, slot_valid_o}, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule